// File: doc/BRIEF.md
# Background Flash Stream Engine

The engine copies a linear run of 32-bit words from flash into a small streaming FIFO without processor involvement. Software programs a starting word address and a word count through a narrow register interface. The engine then requests one word at a time on a request/grant flash port. It issues a request only in cycles when that port carries no other traffic. Each returned word is written into the FIFO, and a consumer such as a DMA channel drains it by reading the data register.

Each accepted request advances the address by one word and lowers the count by one. The stream ends when the count reaches zero. Writing zero to the count register aborts the stream. A read that is still outstanding at that point is marked for discard, and its data is dropped on return. A fresh stream can therefore be programmed and issued at once, while the discarded response is still on its way back.

Register map (byte offsets, bits 1:0 of the offset ignored): 0x0 stream address, 0x4 stream count, 0x8 FIFO data (a read pops one word), 0xC status (bit 0 full, bit 1 empty).

Top module: `flash_stream_engine`

## Requirements
- R1: After reset, the address and count registers read 0, the status reads 0x2 (empty, not full), `fl_req` is low, and a data read returns 0.
- R2: A write to offset 0x0 stores bits 31:2 of the written value as the word address; a read of 0x0 returns that address with bits 1:0 as 0.
- R3: Offset 0x4 holds a 22-bit count. Writing a nonzero value starts streaming. Each accepted request (`fl_req` and `fl_gnt` high in the same cycle) carries the current address on `fl_addr`, then adds 4 to the byte address and subtracts 1 from the count.
- R4: No request is raised while the count is 0, so a stream of N words issues exactly N requests.
- R5: `fl_req` is never high in a cycle where `fl_busy` is high.
- R6: At most one live read is outstanding. No request is raised while the FIFO holds DEPTH words, or holds DEPTH-1 words with a live read pending.
- R7: Returned words enter the FIFO in request order. Status bit 0 (and `fifo_full`) is 1 when the FIFO holds DEPTH words. Status bit 1 (and `fifo_empty`) is 1 when it holds none.
- R8: A read of offset 0x8 from a non-empty FIFO returns the oldest word and removes it.
- R9: A read of offset 0x8 from an empty FIFO returns 0 and leaves the FIFO empty.
- R10: Writing 0 to the count register stops the stream. The response of a read outstanding at that moment is not written to the FIFO. A new nonzero count written afterwards issues its first request in the cycle after that write, even while the discarded response is still pending.
- R11: In a cycle with a register write to offset 0x0 or 0x4, no request is raised. The written value is in effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data offset) |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | ADDR_W | Flash byte address of the request |
| fl_gnt | input | 1 | Flash accepts the request this cycle |
| fl_busy | input | 1 | Flash port used by other traffic this cycle |
| fl_rvalid | input | 1 | Read data returned, in request order |
| fl_rdata | input | DATA_W | Returned read data |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
The bench builds the engine with its defaults: DEPTH 2, a 22-bit count and a 2-bit discard counter. With a depth of two, the full flag and the reservation stall are reached after only two transfers. With the short counter, an abort can be followed at once by a new stream that overlaps the dropped response. A flash model with a programmable latency and per-cycle busy and grant patterns covers the case of a request held back by traffic and the case of a request offered but not granted. Other scenarios include a run that crosses a 64 KiB boundary and an address rewrite landing in the cycle the port turns idle.

// File: rtl/fse_pkg.sv
package fse_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_addr;
        logic wr_cnt;
        logic pop;
    } reg_op_t;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

    function automatic reg_sel_e decode_sel(input logic [REG_AW-1:0] a);
        return reg_sel_e'(a[3:2]);
    endfunction

    function automatic reg_op_t decode_op(input logic wr, input logic rd,
                                          input reg_sel_e sel);
        reg_op_t op;
        op.wr_addr = wr && (sel == SEL_ADDR);
        op.wr_cnt  = wr && (sel == SEL_CNT);
        op.pop     = rd && (sel == SEL_DATA);
        return op;
    endfunction

endpackage

// File: rtl/fse_ctl.sv
module fse_ctl #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_addr,
    input  logic             wr_cnt,
    input  logic [WA_W-1:0]  addr_wdata,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             issue,
    output logic [WA_W-1:0]  addr_word,
    output logic [CNT_W-1:0] cnt,
    output logic             halt
);

    logic [WA_W-1:0]  addr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_addr)
                addr_q <= addr_wdata;
            else if (issue)
                addr_q <= addr_q + WA_W'(1);
            if (wr_cnt)
                cnt_q <= cnt_wdata;
            else if (issue)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign addr_word = addr_q;
    assign cnt       = cnt_q;
    assign halt      = wr_cnt && (cnt_wdata == '0);

    // R4
    no_issue_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        issue |-> (cnt_q != '0));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && !wr_addr) |=> (addr_q == $past(addr_q) + WA_W'(1)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && !wr_cnt) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R11
    write_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_addr || wr_cnt) |-> !issue);

endmodule

// File: rtl/fse_tracker.sv
module fse_tracker #(
    parameter int DROP_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic rvalid,
    input  logic halt,
    output logic live,
    output logic accept,
    output logic drop_full
);

    logic              live_q;
    logic [DROP_W-1:0] drop_q;
    logic              resp_live;
    logic              resp_drop;
    logic              add_drop;

    assign resp_live = rvalid && (drop_q == '0);
    assign resp_drop = rvalid && (drop_q != '0);
    assign add_drop  = halt && live_q && !resp_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            drop_q <= '0;
        end else begin
            if (halt)
                live_q <= 1'b0;
            else if (issue)
                live_q <= 1'b1;
            else if (resp_live)
                live_q <= 1'b0;

            if (add_drop && !resp_drop)
                drop_q <= drop_q + DROP_W'(1);
            else if (resp_drop && !add_drop)
                drop_q <= drop_q - DROP_W'(1);
        end
    end

    assign live      = live_q;
    assign accept    = resp_live && live_q && !halt;
    assign drop_full = (drop_q == '1);

    // R6
    single_out_chk: assert property (@(posedge clk) disable iff (rst)
        issue |-> !live_q);

    // R10
    halt_clears_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> !live_q);

    // R10
    drop_room_chk: assert property (@(posedge clk) disable iff (rst)
        issue |-> (drop_q != '1));

endmodule

// File: rtl/fse_fifo.sv
module fse_fifo #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LW-1:0]     level,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wp_q, rp_q;
    logic [LW-1:0]     lvl_q;
    logic              pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty  = (lvl_q == '0);
    assign full   = (lvl_q == LW'(DEPTH));
    assign pop_ok = pop && !empty;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push && (wp_q == PW'(i)))
                mem[i] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push)
                wp_q <= nxt(wp_q);
            if (pop_ok)
                rp_q <= nxt(rp_q);
            if (push && !pop_ok)
                lvl_q <= lvl_q + LW'(1);
            else if (pop_ok && !push)
                lvl_q <= lvl_q - LW'(1);
        end
    end

    assign head  = empty ? '0 : mem[rp_q];
    assign level = lvl_q;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (lvl_q < LW'(DEPTH)));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (lvl_q == '0));

    // R8
    pop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push) |=> (lvl_q == $past(lvl_q) - LW'(1)));

endmodule

// File: rtl/flash_stream_engine.sv
module flash_stream_engine
    import fse_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2,
    parameter int DROP_W = 2,
    localparam int WA_W  = ADDR_W - 2,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic              fl_gnt,
    input  logic              fl_busy,
    input  logic              fl_rvalid,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fifo_full,
    output logic              fifo_empty
);

    reg_sel_e          sel;
    reg_op_t           op;
    fifo_flags_t       flags;
    logic [WA_W-1:0]   addr_word;
    logic [CNT_W-1:0]  cnt;
    logic              halt;
    logic              issue;
    logic              live;
    logic              accept;
    logic              drop_full;
    logic [DATA_W-1:0] head;
    logic [LW-1:0]     level;
    logic [LW:0]       reserved;
    logic              can_issue;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[1:0], reg_addr[1:0]};

    assign sel = decode_sel(reg_addr);
    assign op  = decode_op(reg_wr, reg_rd, sel);

    fse_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .wr_addr    (op.wr_addr),
        .wr_cnt     (op.wr_cnt),
        .addr_wdata (reg_wdata[ADDR_W-1:2]),
        .cnt_wdata  (reg_wdata[CNT_W-1:0]),
        .issue      (issue),
        .addr_word  (addr_word),
        .cnt        (cnt),
        .halt       (halt)
    );

    fse_tracker #(.DROP_W(DROP_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .rvalid    (fl_rvalid),
        .halt      (halt),
        .live      (live),
        .accept    (accept),
        .drop_full (drop_full)
    );

    fse_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (accept),
        .din   (fl_rdata),
        .pop   (op.pop),
        .head  (head),
        .level (level),
        .full  (flags.full),
        .empty (flags.empty)
    );

    assign reserved  = (LW+1)'(level) + (LW+1)'(live);
    assign can_issue = (cnt != '0) && !live && !drop_full
                     && (reserved < (LW+1)'(DEPTH))
                     && !op.wr_addr && !op.wr_cnt;
    assign fl_req    = can_issue && !fl_busy;
    assign issue     = fl_req && fl_gnt;
    assign fl_addr   = {addr_word, 2'b00};

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_ADDR: reg_rdata = 32'({addr_word, 2'b00});
            SEL_CNT:  reg_rdata = 32'(cnt);
            SEL_DATA: reg_rdata = 32'(head);
            SEL_STAT: reg_rdata = {30'b0, flags.empty, flags.full};
            default:  reg_rdata = '0;
        endcase
    end

    assign fifo_full  = flags.full;
    assign fifo_empty = flags.empty;

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R6
    full_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !op.pop) |=> fifo_full || $past(op.pop));

endmodule

// File: tb/flash_stream_engine_bench.sv
module flash_stream_engine_bench;

    typedef struct packed {
        logic [31:0] start;
        logic [7:0]  words;
        logic [7:0]  busy;
        logic [7:0]  gnt;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0000_1000, 8'd3, 8'h00, 8'hFF, 4'd1},
        '{32'h0004_0F00, 8'd6, 8'hAA, 8'hFF, 4'd3},
        '{32'h00FF_FFF8, 8'd4, 8'h00, 8'h5B, 4'd2},
        '{32'h0010_0000, 8'd1, 8'h6E, 8'h9C, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_req;
    logic [31:0] fl_addr;
    logic        fl_gnt, fl_busy;
    logic        fl_rvalid = 1'b0;
    logic [31:0] fl_rdata = '0;
    logic        fifo_full, fifo_empty;

    logic [31:0] cyc = '0;
    logic [7:0]  busy_mask = '0;
    logic [7:0]  gnt_mask = 8'hFF;
    int          lat = 1;
    int          nchk = 0, nfail = 0;

    logic [31:0] q_addr [16];
    logic [31:0] q_due  [16];
    int          q_head = 0, q_tail = 0;

    assign fl_busy = busy_mask[cyc[2:0]];
    assign fl_gnt  = gnt_mask[cyc[2:0]];

    always #10 clk = ~clk;

    flash_stream_engine u_flash_stream_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_gnt(fl_gnt),
        .fl_busy(fl_busy), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    function automatic logic [31:0] fdata(input logic [31:0] a);
        return a ^ 32'hC3A5_0F1E;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && fl_req && fl_gnt) begin
            q_addr[q_tail % 16] = fl_addr;
            q_due[q_tail % 16]  = cyc + 32'(lat);
            q_tail = q_tail + 1;
        end
        if (!rst && fl_req && fl_busy) begin
            nfail++;
            $display("FAIL R5 request while busy actual=1 expected=0");
        end
        if (cyc == 32'd60000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 60000);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (q_head != q_tail && q_due[q_head % 16] <= cyc) begin
            fl_rvalid = 1'b1;
            fl_rdata  = fdata(q_addr[q_head % 16]);
            q_head    = q_head + 1;
        end else begin
            fl_rvalid = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic drain(input string tag, input logic [31:0] start, input int n);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            int polls = 0;
            rd_reg(4'hC, d);
            while (d[1] && polls < 300) begin
                rd_reg(4'hC, d);
                polls++;
            end
            rd_reg(4'h8, d);
            chk(tag, d, fdata(start + 32'(4 * i)));
        end
    endtask

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 fl_req", {31'b0, fl_req}, 32'h0);
        rd_reg(4'hC, d); chk("R1 status", d, 32'h2);
        rd_reg(4'h0, d); chk("R1 addr", d, 32'h0);
        rd_reg(4'h4, d); chk("R1 count", d, 32'h0);
        // R9 pop from empty
        rd_reg(4'h8, d); chk("R9 empty pop data", d, 32'h0);
        rd_reg(4'hC, d); chk("R9 still empty", d, 32'h2);
        // R2 address bits 1:0 read as 0
        wr_reg(4'h0, 32'h1234_5677);
        rd_reg(4'h0, d); chk("R2 addr readback", d, 32'h1234_5674);

        // R3 R4 R7 R8: table of streams
        for (int v = 0; v < 4; v++) begin
            busy_mask = VECS[v].busy;
            gnt_mask  = VECS[v].gnt;
            lat       = int'(VECS[v].lat);
            wr_reg(4'h0, VECS[v].start);
            wr_reg(4'h4, 32'(VECS[v].words));
            drain("R8 stream data", VECS[v].start, int'(VECS[v].words));
            repeat (10) @(negedge clk);
            rd_reg(4'h4, d); chk("R4 count ends at 0", d, 32'h0);
            rd_reg(4'h0, d); chk("R3 addr advanced", d, VECS[v].start + 32'(4 * VECS[v].words));
            rd_reg(4'hC, d); chk("R4 no extra word", d, 32'h2);
        end

        // R6 R7 full FIFO stalls the stream
        busy_mask = 8'h00; gnt_mask = 8'hFF; lat = 2;
        wr_reg(4'h0, 32'h0002_0000);
        wr_reg(4'h4, 32'd5);
        repeat (20) @(negedge clk);
        rd_reg(4'hC, d); chk("R7 full flag", d, 32'h1);
        chk("R7 full port", {31'b0, fifo_full}, 32'h1);
        rd_reg(4'h4, d); chk("R6 count stalled", d, 32'd3);
        rd_reg(4'h0, d); chk("R6 addr stalled", d, 32'h0002_0008);
        drain("R7 order", 32'h0002_0000, 5);

        // R11 write in the cycle the port turns idle
        busy_mask = 8'hFF;
        wr_reg(4'h0, 32'h0003_0000);
        wr_reg(4'h4, 32'd3);
        @(negedge clk);
        busy_mask = 8'h00;
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0005_0040;
        #1 chk("R11 no req on write", {31'b0, fl_req}, 32'h0);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R11 new addr used", fl_addr, 32'h0005_0040);
        chk("R11 req next cycle", {31'b0, fl_req}, 32'h1);
        drain("R11 data", 32'h0005_0040, 3);

        // R10 halt with a read in flight, restart at once
        lat = 8;
        wr_reg(4'h0, 32'h0007_0000);
        wr_reg(4'h4, 32'd4);
        begin
            int polls = 0;
            rd_reg(4'h4, d);
            while (d == 32'd4 && polls < 50) begin
                rd_reg(4'h4, d);
                polls++;
            end
        end
        wr_reg(4'h4, 32'd0);
        wr_reg(4'h0, 32'h0009_0000);
        wr_reg(4'h4, 32'd1);
        rd_reg(4'h4, d);
        rd_reg(4'h4, d); chk("R10 restart issued", d, 32'h0);
        drain("R10 new data", 32'h0009_0000, 1);
        repeat (25) @(negedge clk);
        rd_reg(4'hC, d); chk("R10 dropped word", d, 32'h2);
        rd_reg(4'h8, d); chk("R10 nothing left", d, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule